// File: doc/BRIEF.md
# Flag-Setting Data-Processing ALU

This block is the integer execution unit of a small load/store RISC core. Each cycle it receives an operation select, two operands and a carry bit from the operand shifter. It returns a result, a write enable for the destination register, and a set of N, Z, C and V condition flags. The flags sit in a register inside the block, so they carry over from one operation to the next. The stored carry is also the carry-in for the carry-consuming arithmetic operations. The second operand arrives already shifted.

The operations are logical (AND, XOR, OR, clear-bits), pass and inverted pass of the second operand, add and subtract in forward and reverse order, carry-consuming variants of these, and four test forms. The test forms only produce flags. They always update the flags and never request a register write. The other operations change the flags only when the caller asserts the update enable.

Top module: `dp_flag_alu`

## Requirements
- R1: Logical results: select 0 gives A AND B, 1 gives A XOR B, 12 gives A OR B, 14 gives A AND NOT B. Selects 8 and 9 form A AND B and A XOR B on `result` as well.
- R2: Select 13 drives B onto `result`. Select 15 drives the bitwise inverse of B.
- R3: Select 4 gives A+B, 2 gives A−B and 3 gives B−A, all modulo 2^W. Select 10 forms A−B and select 11 forms A+B on `result`.
- R4: With C the stored carry flag, select 5 gives A+B+C, 6 gives A−B+C−1 and 7 gives B−A+C−1, modulo 2^W.
- R5: Selects 8 to 11 keep `rd_we` low and update the flags on the next clock edge whatever the value of `upd_flags`.
- R6: Every select outside 8 to 11 drives `rd_we` high.
- R7: When `upd_flags` is low and the select is outside 8 to 11, all four flags keep their values across the clock edge.
- R8: On a flag update, N takes bit W−1 of the computed value and Z is set exactly when the computed value is zero.
- R9: On a flag update by an arithmetic select (2–7, 10, 11), C takes the adder carry-out. For subtraction this means C is 1 when no borrow occurs. V is set on signed two's-complement overflow.
- R10: On a flag update by a logical, pass or test select (0, 1, 8, 9, 12–15), C takes `shift_cout` and V keeps its value.
- R11: While `rst_n` is low, all four flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the flag register |
| rst_n | input | 1 | Asynchronous active-low reset of the flags |
| op_sel | input | 4 | Operation select (encodings listed in R1–R5) |
| opnd_a | input | W | First operand |
| opnd_b | input | W | Second operand, already shifted |
| shift_cout | input | 1 | Carry-out from the shifter, used as C by logical selects |
| upd_flags | input | 1 | Flag update request for selects that write a register |
| result | output | W | Computed value |
| rd_we | output | 1 | Destination register write enable |
| flag_n | output | 1 | Stored negative flag |
| flag_z | output | 1 | Stored zero flag |
| flag_c | output | 1 | Stored carry flag |
| flag_v | output | 1 | Stored overflow flag |

## Verification
Two things can happen in one cycle. A carry-consuming operation reads the stored C and produces a new C that replaces it at the same edge. A test operation forces a flag update even when the update request is low. The sweep provokes both. Before every vector it loads a known carry with a pass operation, then issues each select for every pair of operands at a small width, with the update request and shifter carry toggled across the vectors. A bench model recomputes sums, borrows and signed ranges with plain integers and holds its own copy of the flags. At the next falling edge the bench judges the stored flags against that model, so a stale carry or a missed forced update shows up as a mismatch.

// File: rtl/alu_pkg.sv
package alu_pkg;

  typedef enum logic [3:0] {
    OP_AND    = 4'd0,
    OP_XOR    = 4'd1,
    OP_SUB    = 4'd2,
    OP_RSUB   = 4'd3,
    OP_ADD    = 4'd4,
    OP_ADDC   = 4'd5,
    OP_SUBC   = 4'd6,
    OP_RSUBC  = 4'd7,
    OP_TSTAND = 4'd8,
    OP_TSTXOR = 4'd9,
    OP_CMPSUB = 4'd10,
    OP_CMPADD = 4'd11,
    OP_OR     = 4'd12,
    OP_PASS   = 4'd13,
    OP_CLR    = 4'd14,
    OP_PASSN  = 4'd15
  } alu_op_e;

  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
  } alu_flags_t;

  // Flag-only selects: never write, always update flags.
  function automatic logic op_is_test(alu_op_e op);
    return op inside {OP_TSTAND, OP_TSTXOR, OP_CMPSUB, OP_CMPADD};
  endfunction

  // Selects whose value comes from the adder.
  function automatic logic op_is_arith(alu_op_e op);
    return op inside {OP_SUB, OP_RSUB, OP_ADD, OP_ADDC, OP_SUBC,
                      OP_RSUBC, OP_CMPSUB, OP_CMPADD};
  endfunction

endpackage

// File: rtl/alu_logic_unit.sv
module alu_logic_unit
  import alu_pkg::*;
#(
  parameter int W = 32
) (
  input  alu_op_e        op,
  input  logic [W-1:0]   a,
  input  logic [W-1:0]   b,
  output logic [W-1:0]   y
);

  function automatic logic [W-1:0] logic_eval(alu_op_e o, logic [W-1:0] x,
                                              logic [W-1:0] z);
    logic [W-1:0] r;
    unique case (o)
      OP_AND, OP_TSTAND: r = x & z;
      OP_XOR, OP_TSTXOR: r = x ^ z;
      OP_OR:             r = x | z;
      OP_CLR:            r = x & ~z;
      OP_PASS:           r = z;
      OP_PASSN:          r = ~z;
      default:           r = '0;
    endcase
    return r;
  endfunction

  assign y = logic_eval(op, a, b);

endmodule

// File: rtl/alu_addsub_unit.sv
module alu_addsub_unit
  import alu_pkg::*;
#(
  parameter int W = 32
) (
  input  alu_op_e        op,
  input  logic [W-1:0]   a,
  input  logic [W-1:0]   b,
  input  logic           cin,
  output logic [W-1:0]   sum,
  output logic           cout,
  output logic           ovf
);

  localparam int MSB = W - 1;

  logic [W-1:0] add_x;
  logic [W-1:0] add_y;
  logic         add_ci;
  logic [W:0]   add_full;

  // Every arithmetic select maps onto one adder: x + y + ci.
  always_comb begin
    add_x  = a;
    add_y  = b;
    add_ci = 1'b0;
    unique case (op)
      OP_ADD, OP_CMPADD: begin add_x = a; add_y = b;  add_ci = 1'b0; end
      OP_ADDC:           begin add_x = a; add_y = b;  add_ci = cin;  end
      OP_SUB, OP_CMPSUB: begin add_x = a; add_y = ~b; add_ci = 1'b1; end
      OP_SUBC:           begin add_x = a; add_y = ~b; add_ci = cin;  end
      OP_RSUB:           begin add_x = b; add_y = ~a; add_ci = 1'b1; end
      OP_RSUBC:          begin add_x = b; add_y = ~a; add_ci = cin;  end
      default:           begin add_x = a; add_y = b;  add_ci = 1'b0; end
    endcase
  end

  function automatic logic [W:0] wide_add(logic [W-1:0] x, logic [W-1:0] y,
                                          logic ci);
    return {1'b0, x} + {1'b0, y} + {{W{1'b0}}, ci};
  endfunction

  assign add_full = wide_add(add_x, add_y, add_ci);
  assign sum      = add_full[W-1:0];
  assign cout     = add_full[W];
  assign ovf      = (add_x[MSB] == add_y[MSB]) && (add_full[MSB] != add_x[MSB]);

endmodule

// File: rtl/alu_flag_reg.sv
module alu_flag_reg
  import alu_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         upd,
  input  logic         from_adder,
  input  logic [W-1:0] value,
  input  logic         add_cout,
  input  logic         add_ovf,
  input  logic         shift_c,
  output alu_flags_t   flags_q
);

  alu_flags_t flags_d;

  always_comb begin
    flags_d = flags_q;
    if (upd) begin
      flags_d.n = value[W-1];
      flags_d.z = (value == '0);
      flags_d.c = from_adder ? add_cout : shift_c;
      flags_d.v = from_adder ? add_ovf  : flags_q.v;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags_q <= '0;
    else        flags_q <= flags_d;
  end

endmodule

// File: rtl/dp_flag_alu.sv
module dp_flag_alu
  import alu_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [3:0]   op_sel,
  input  logic [W-1:0] opnd_a,
  input  logic [W-1:0] opnd_b,
  input  logic         shift_cout,
  input  logic         upd_flags,
  output logic [W-1:0] result,
  output logic         rd_we,
  output logic         flag_n,
  output logic         flag_z,
  output logic         flag_c,
  output logic         flag_v
);

  alu_op_e      op;
  alu_flags_t   flags_q;
  logic [W-1:0] logic_y;
  logic [W-1:0] arith_y;
  logic         arith_cout;
  logic         arith_ovf;
  logic         arith_sel;
  logic         test_sel;
  logic         flag_upd_eff;

  assign op           = alu_op_e'(op_sel);
  assign arith_sel    = op_is_arith(op);
  assign test_sel     = op_is_test(op);
  assign flag_upd_eff = upd_flags | test_sel;

  alu_logic_unit #(.W(W)) u_logic (
    .op (op),
    .a  (opnd_a),
    .b  (opnd_b),
    .y  (logic_y)
  );

  alu_addsub_unit #(.W(W)) u_addsub (
    .op   (op),
    .a    (opnd_a),
    .b    (opnd_b),
    .cin  (flags_q.c),
    .sum  (arith_y),
    .cout (arith_cout),
    .ovf  (arith_ovf)
  );

  assign result = arith_sel ? arith_y : logic_y;
  assign rd_we  = ~test_sel;

  alu_flag_reg #(.W(W)) u_flags (
    .clk        (clk),
    .rst_n      (rst_n),
    .upd        (flag_upd_eff),
    .from_adder (arith_sel),
    .value      (result),
    .add_cout   (arith_cout),
    .add_ovf    (arith_ovf),
    .shift_c    (shift_cout),
    .flags_q    (flags_q)
  );

  assign flag_n = flags_q.n;
  assign flag_z = flags_q.z;
  assign flag_c = flags_q.c;
  assign flag_v = flags_q.v;

endmodule

// File: rtl/alu_flag_chk.sv
module alu_flag_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic [3:0]   op_sel,
  input logic         upd_flags,
  input logic         shift_cout,
  input logic [W-1:0] result,
  input logic         rd_we,
  input logic         arith_sel,
  input logic         flag_n,
  input logic         flag_z,
  input logic         flag_c,
  input logic         flag_v
);

  logic is_test;
  assign is_test = (op_sel[3:2] == 2'b10);

  assert_test_no_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
    is_test |-> !rd_we);

  assert_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !is_test |-> rd_we);

  assert_flags_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!upd_flags && !is_test) |=> $stable({flag_n, flag_z, flag_c, flag_v}));

  assert_nz_track_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_flags || is_test) |=>
      (flag_z == ($past(result) == '0)) && (flag_n == $past(result[W-1])));

  assert_logic_carry_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ((upd_flags || is_test) && !arith_sel) |=>
      (flag_c == $past(shift_cout)) && $stable(flag_v));

  assert_reset_clear_R11: assert property (@(posedge clk)
    $rose(rst_n) |-> ({flag_n, flag_z, flag_c, flag_v} == 4'b0000));

endmodule

bind dp_flag_alu alu_flag_chk #(.W(W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .op_sel     (op_sel),
  .upd_flags  (upd_flags),
  .shift_cout (shift_cout),
  .result     (result),
  .rd_we      (rd_we),
  .arith_sel  (arith_sel),
  .flag_n     (flag_n),
  .flag_z     (flag_z),
  .flag_c     (flag_c),
  .flag_v     (flag_v)
);

// File: tb/tb_dp_flag_alu.sv
`timescale 1ns/100ps
module tb_dp_flag_alu;

  localparam int W    = 4;
  localparam int MASK = (1 << W) - 1;
  localparam int HALF = 1 << (W - 1);

  logic         clk = 1'b0;
  logic         rst_n;
  logic [3:0]   op_sel;
  logic [W-1:0] opnd_a, opnd_b;
  logic         shift_cout, upd_flags;
  logic [W-1:0] result;
  logic         rd_we, flag_n, flag_z, flag_c, flag_v;

  int    checks = 0;
  int    errors = 0;
  bit    done   = 1'b0;
  logic [3:0] model;      // {n,z,c,v}
  string ftag = "R7";

  always #2.5 clk = ~clk;

  dp_flag_alu #(.W(W)) dut (
    .clk(clk), .rst_n(rst_n), .op_sel(op_sel), .opnd_a(opnd_a),
    .opnd_b(opnd_b), .shift_cout(shift_cout), .upd_flags(upd_flags),
    .result(result), .rd_we(rd_we), .flag_n(flag_n), .flag_z(flag_z),
    .flag_c(flag_c), .flag_v(flag_v)
  );

  task automatic check(string tag, bit ok, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h (op %0d a %0h b %0h)",
               tag, act, exp, op_sel, opnd_a, opnd_b);
    end
  endtask

  function automatic int sgn(int x);
    return (x >= HALF) ? x - (1 << W) : x;
  endfunction

  function automatic bit ovr(int s);
    return (s > HALF - 1) || (s < -HALF);
  endfunction

  task automatic check_flags();
    logic [3:0] got;
    got = {flag_n, flag_z, flag_c, flag_v};
    check(ftag, got == model, int'(got), int'(model));
  endtask

  task automatic step(int o, int av, int bv, bit s, bit u);
    int t, sv, r, ci;
    bit c, v, ar, ts;
    string rtag;
    @(negedge clk);
    check_flags();
    op_sel = o[3:0]; opnd_a = av[W-1:0]; opnd_b = bv[W-1:0];
    shift_cout = s; upd_flags = u;
    #1;
    ci = int'(model[1]);
    ts = (o >= 8 && o <= 11);
    ar = (o >= 2 && o <= 7) || o == 10 || o == 11;
    t = 0; sv = 0; c = 1'b0; rtag = "R1";
    case (o)
      0, 8:  t = av & bv;
      1, 9:  t = av ^ bv;
      12:    t = av | bv;
      14:    t = av & (~bv & MASK);
      13:    begin t = bv;         rtag = "R2"; end
      15:    begin t = ~bv & MASK; rtag = "R2"; end
      4, 11: begin t = av + bv;  c = t > MASK; sv = sgn(av) + sgn(bv); rtag = "R3"; end
      2, 10: begin t = av - bv;  c = t >= 0;   sv = sgn(av) - sgn(bv); rtag = "R3"; end
      3:     begin t = bv - av;  c = t >= 0;   sv = sgn(bv) - sgn(av); rtag = "R3"; end
      5:     begin t = av + bv + ci;     c = t > MASK; sv = sgn(av) + sgn(bv) + ci;     rtag = "R4"; end
      6:     begin t = av - bv + ci - 1; c = t >= 0;   sv = sgn(av) - sgn(bv) + ci - 1; rtag = "R4"; end
      7:     begin t = bv - av + ci - 1; c = t >= 0;   sv = sgn(bv) - sgn(av) + ci - 1; rtag = "R4"; end
      default: t = 0;
    endcase
    r = t & MASK;
    v = ovr(sv);
    check(rtag, int'(result) == r, int'(result), r);
    if (ts) check("R5", rd_we == 1'b0, int'(rd_we), 0);
    else    check("R6", rd_we == 1'b1, int'(rd_we), 1);
    if (u || ts) begin
      model = {r[W-1], r == 0, ar ? c : s, ar ? v : model[0]};
      ftag  = ar ? "R8/R9" : "R8/R10";
    end else begin
      ftag = "R7";
    end
  endtask

  initial begin
    rst_n = 1'b0; op_sel = 4'd0; opnd_a = '0; opnd_b = '0;
    shift_cout = 1'b0; upd_flags = 1'b0;
    model = 4'b0000;
    repeat (3) @(negedge clk);
    check("R11", {flag_n, flag_z, flag_c, flag_v} == 4'b0000,
          int'({flag_n, flag_z, flag_c, flag_v}), 0);
    rst_n = 1'b1;
    for (int o = 0; o < 16; o++)
      for (int av = 0; av <= MASK; av++)
        for (int bv = 0; bv <= MASK; bv++)
          for (int ci = 0; ci < 2; ci++) begin
            step(13, 0, 0, ci[0], 1'b1);   // preload C (R10 path)
            step(o, av, bv, av[0] ^ bv[2] ^ ci[0], bv[1] ^ ci[0] ^ av[3]);
          end
    // Signed overflow on a flag update: 7+1 sets V, N; then reset clears all
    step(4, 7, 1, 1'b0, 1'b1);
    step(13, 0, 0, 1'b1, 1'b0);
    @(negedge clk);
    check_flags();
    rst_n = 1'b0;
    #1;
    check("R11", {flag_n, flag_z, flag_c, flag_v} == 4'b0000,
          int'({flag_n, flag_z, flag_c, flag_v}), 0);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog (all requirements): actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule